// File: doc/BRIEF.md
# Frequency-Locked Loop Tuner

This block steers a digitally controlled oscillator so that its frequency settles at a programmed multiple of a reference. Once per reference period the surrounding logic delivers a pulse together with the number of oscillator cycles counted in that period. The block compares that count with the programmed ratio and moves a 6-bit coarse code first. After the coarse code has settled it moves a 10-bit fine code. It reports coarse and fine lock on two separate flags. It can also hold the downstream clock gate closed until lock.

Three operating styles are selected by control bits. Open loop drives the calibration preload values straight onto the codes and does no tracking. Closed loop runs the coarse-then-fine search. Frame recovery uses a 1 kHz frame pulse as the reference, keeps the coarse code at its calibrated value and tunes only the fine code. While no frame pulse arrives, the calibrated codes stay in place. After a code change the next reference period is normally skipped so that the oscillator can settle, and a control bit turns this pause off.

Top module: `fll_tuner`

## Requirements
- R1: A write is accepted when `cfg_we` is high and `cfg_ready` is high. `cfg_sel` selects the target: 0 is control, 1 is the multiplier (bits 15:0), 2 is the step limits (coarse limit in bits 5:0, fine limit in bits 25:16) and 3 is the calibration preload (coarse in bits 5:0, fine in bits 25:16). After an accepted write `cfg_ready` is low for exactly 2 cycles, and any write presented while it is low is discarded.
- R2: The control bits are: bit 0 enable, bit 1 closed loop, bit 2 wait for lock, bit 3 frame recovery, bit 4 settling-pause disable. Tracking is active when enable is set and either closed loop or frame recovery is set. While tracking is off, the codes take the calibration values one cycle later, reference pulses have no effect and both lock flags are low. After reset all codes and flags are 0 and `cfg_ready` is 1.
- R3: The error is the multiplier minus `osc_count`. In the coarse phase the error magnitude is shifted right by 3 and clamped to the coarse step limit. The result is added to the coarse code for a positive error and subtracted for a negative one, saturating at 0 and 63. This happens only on a reference pulse.
- R4: Coarse lock is set when the error sign reverses for the second time (zero errors neither count nor reset the sign) or when the shifted magnitude is zero. From then on the coarse code is frozen and the fine phase runs.
- R5: In the fine phase the error magnitude is clamped to the fine step limit and applied to the fine code with the error's sign, saturating at 0 and 1023.
- R6: Fine lock is set when the absolute error is at most 1 on 4 consecutive tuning periods. A tuning period with a larger error clears the flag and restarts the run.
- R7: `clk_gate_en` is low when the block is disabled. While tracking with wait for lock set, it stays low until lock: both flags in closed loop, fine lock alone in frame recovery. Otherwise it is high while enabled.
- R8: In frame recovery the coarse code stays at its calibration value whatever the error, coarse lock stays low, and without pulses both codes hold their calibration values.
- R9: A reference pulse that changes a code makes the next pulse a settling pause, during which nothing is updated. When the settling-pause disable bit is set, every pulse tunes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write data |
| ref_tick | input | 1 | One-cycle pulse at the end of each reference period |
| osc_count | input | 16 | Oscillator cycles counted in the period that just ended |
| coarse_code | output | 6 | Coarse oscillator control code |
| fine_code | output | 10 | Fine oscillator control code |
| coarse_lock | output | 1 | Coarse search settled |
| fine_lock | output | 1 | Fine search settled |
| clk_gate_en | output | 1 | Enable for the downstream clock gate |
| cfg_ready | output | 1 | High when a configuration write would be accepted |

## Verification
The assertions check several properties on every cycle:
- the two-cycle ready drop after an accepted write;
- that both locks are low once tracking is off;
- that the codes never move between reference pulses;
- that the coarse code is frozen after coarse lock and throughout frame recovery;
- that fine lock rises only after a pulse;
- that the gate stays shut while fine lock is missing under wait for lock.

The exact step sizes, the clamping and saturation values, the sign-reversal count, the four-period lock run, the skipped period after a code change and the discarding of writes during the busy window depend on chosen error sequences. Only the bench scenarios show these, and so does convergence against a modelled oscillator.

// File: rtl/fll_pkg.sv
// Shared constants and types for the frequency-locked loop tuner.
// Assumes a 32-bit configuration write bus and a 2-bit register select.
package fll_pkg;
    localparam int COARSE_W = 6;
    localparam int FINE_W   = 10;
    localparam int MULT_W   = 16;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = 2;
    localparam int HI_LSB   = 16;   // second field of the step and calibration words

    // control word bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_CLOSED  = 1;
    localparam int CTL_WAIT    = 2;
    localparam int CTL_FRAME   = 3;
    localparam int CTL_NOCHILL = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_MULT = 2'd1,
        SEL_STEP = 2'd2,
        SEL_CAL  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic                enable;
        logic                closed;
        logic                wait_lock;
        logic                frame;
        logic                no_chill;
        logic [MULT_W-1:0]   mult;
        logic [COARSE_W-1:0] cstep;
        logic [FINE_W-1:0]   fstep;
        logic [COARSE_W-1:0] cal_coarse;
        logic [FINE_W-1:0]   cal_fine;
    } cfg_t;
endpackage

// File: rtl/fll_cfg_regs.sv
// Configuration register file with a write-busy window.
// Assumes: a write is taken only while ready; each accepted write blocks
// further writes for BUSY_CYC cycles.
module fll_cfg_regs
    import fll_pkg::*;
#(
    parameter int BUSY_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output cfg_t              cfg
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0] busy_q;
    logic          take;
    logic          unused_hi;

    assign take      = we && (busy_q == '0);
    assign ready     = (busy_q == '0);
    assign unused_hi = ^wdata[DATA_W-1:HI_LSB+FINE_W];

    // busy window counter started by each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= '0;
        else if (take)
            busy_q <= BW'(BUSY_CYC);
        else if (busy_q != '0)
            busy_q <= busy_q - 1'b1;
    end

    // register update for the selected target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (take) begin
            case (cfg_sel_e'(sel))
                SEL_CTRL: begin
                    cfg.enable    <= wdata[CTL_EN];
                    cfg.closed    <= wdata[CTL_CLOSED];
                    cfg.wait_lock <= wdata[CTL_WAIT];
                    cfg.frame     <= wdata[CTL_FRAME];
                    cfg.no_chill  <= wdata[CTL_NOCHILL];
                end
                SEL_MULT: cfg.mult <= wdata[MULT_W-1:0];
                SEL_STEP: begin
                    cfg.cstep <= wdata[COARSE_W-1:0];
                    cfg.fstep <= wdata[HI_LSB +: FINE_W];
                end
                SEL_CAL: begin
                    cfg.cal_coarse <= wdata[COARSE_W-1:0];
                    cfg.cal_fine   <= wdata[HI_LSB +: FINE_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fll_err_unit.sv
// Combinational error evaluation: signed count error, clamped coarse and fine
// step magnitudes, and the small-error and zero-step indications.
// Assumes the error width covers both the multiplier and the count.
module fll_err_unit
    import fll_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int COARSE_SHIFT = 3
) (
    input  logic [MULT_W-1:0]   mult,
    input  logic [CNT_W-1:0]    count,
    input  logic [COARSE_W-1:0] cstep,
    input  logic [FINE_W-1:0]   fstep,
    output logic                err_neg,
    output logic                err_zero,
    output logic                err_small,
    output logic                coarse_mag_zero,
    output logic [COARSE_W-1:0] coarse_delta,
    output logic [FINE_W-1:0]   fine_delta
);
    localparam int EW = ((MULT_W > CNT_W) ? MULT_W : CNT_W) + 1;

    logic signed [EW-1:0] err;
    logic        [EW-1:0] mag;
    logic        [EW-1:0] cmag;

    // error, magnitude and clamped step sizes
    always_comb begin
        err          = $signed(EW'(mult)) - $signed(EW'(count));
        mag          = err[EW-1] ? -err : err;
        cmag         = mag >> COARSE_SHIFT;
        coarse_delta = (cmag > EW'(cstep)) ? cstep : cmag[COARSE_W-1:0];
        fine_delta   = (mag > EW'(fstep)) ? fstep : mag[FINE_W-1:0];
    end

    assign err_neg         = err[EW-1];
    assign err_zero        = (err == '0);
    assign err_small       = (mag <= EW'(1));
    assign coarse_mag_zero = (cmag == '0);
endmodule

// File: rtl/fll_track.sv
// Tracking engine: holds the codes, runs the coarse search until lock and
// then the fine search, inserts a settling pause after a code change, and
// keeps the lock flags. Assumes ref_tick is a single-cycle pulse.
module fll_track
    import fll_pkg::*;
#(
    parameter int LOCK_RUN = 4,
    parameter int REV_LOCK = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cfg_t                cfg,
    input  logic                ref_tick,
    input  logic                err_neg,
    input  logic                err_zero,
    input  logic                err_small,
    input  logic                coarse_mag_zero,
    input  logic [COARSE_W-1:0] coarse_delta,
    input  logic [FINE_W-1:0]   fine_delta,
    output logic [COARSE_W-1:0] coarse_code,
    output logic [FINE_W-1:0]   fine_code,
    output logic                coarse_lock,
    output logic                fine_lock,
    output logic                tracking
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam int REV_W = $clog2(REV_LOCK + 1);

    logic [COARSE_W-1:0] coarse_q, coarse_nx;
    logic [FINE_W-1:0]   fine_q, fine_nx;
    logic [COARSE_W:0]   coarse_sum;
    logic [FINE_W:0]     fine_sum;
    logic                cl_q, fl_q, chill_q;
    logic [RUN_W-1:0]    run_q;
    logic [REV_W-1:0]    rev_q;
    logic                last_neg_q, sign_seen_q;
    logic                fine_phase, act, rev_hit;

    assign tracking   = cfg.enable & (cfg.closed | cfg.frame);
    assign fine_phase = cfg.frame | cl_q;
    assign act        = tracking & ref_tick & ~(chill_q & ~cfg.no_chill);
    assign rev_hit    = ~err_zero & sign_seen_q & (err_neg != last_neg_q);

    // saturating next values of both codes
    always_comb begin
        coarse_sum = {1'b0, coarse_q} + {1'b0, coarse_delta};
        fine_sum   = {1'b0, fine_q} + {1'b0, fine_delta};
        if (err_neg) begin
            coarse_nx = (coarse_delta > coarse_q) ? '0 : coarse_q - coarse_delta;
            fine_nx   = (fine_delta > fine_q) ? '0 : fine_q - fine_delta;
        end else begin
            coarse_nx = coarse_sum[COARSE_W] ? '1 : coarse_sum[COARSE_W-1:0];
            fine_nx   = fine_sum[FINE_W] ? '1 : fine_sum[FINE_W-1:0];
        end
    end

    // code registers and settling-pause flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
            chill_q  <= 1'b0;
        end else if (!tracking) begin
            coarse_q <= cfg.cal_coarse;
            fine_q   <= cfg.cal_fine;
            chill_q  <= 1'b0;
        end else if (ref_tick) begin
            if (!act) begin
                chill_q <= 1'b0;
            end else if (fine_phase) begin
                fine_q  <= fine_nx;
                chill_q <= (fine_nx != fine_q);
            end else begin
                coarse_q <= coarse_nx;
                chill_q  <= (coarse_nx != coarse_q);
            end
        end
    end

    // coarse lock from sign reversals or a zero scaled step
    always_ff @(posedge clk) begin
        if (!rst_n || !tracking) begin
            cl_q        <= 1'b0;
            rev_q       <= '0;
            last_neg_q  <= 1'b0;
            sign_seen_q <= 1'b0;
        end else if (act && !fine_phase) begin
            if (!err_zero) begin
                last_neg_q  <= err_neg;
                sign_seen_q <= 1'b1;
            end
            if (rev_hit)
                rev_q <= rev_q + 1'b1;
            if (coarse_mag_zero || (rev_hit && rev_q == REV_W'(REV_LOCK - 1)))
                cl_q <= 1'b1;
        end
    end

    // fine lock from a run of small errors
    always_ff @(posedge clk) begin
        if (!rst_n || !tracking) begin
            run_q <= '0;
            fl_q  <= 1'b0;
        end else if (act && fine_phase) begin
            if (err_small) begin
                if (run_q != RUN_W'(LOCK_RUN))
                    run_q <= run_q + 1'b1;
                if (run_q >= RUN_W'(LOCK_RUN - 1))
                    fl_q <= 1'b1;
            end else begin
                run_q <= '0;
                fl_q  <= 1'b0;
            end
        end
    end

    assign coarse_code = coarse_q;
    assign fine_code   = fine_q;
    assign coarse_lock = cl_q;
    assign fine_lock   = fl_q;
endmodule

// File: rtl/fll_tuner.sv
// Top of the frequency-locked loop tuner: configuration registers, error
// evaluation, tracking engine and the output clock gate decision.
// Assumes osc_count is valid in the cycle ref_tick is high.
module fll_tuner
    import fll_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int COARSE_SHIFT = 3,
    parameter int LOCK_RUN     = 4,
    parameter int REV_LOCK     = 2,
    parameter int BUSY_CYC     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                ref_tick,
    input  logic [CNT_W-1:0]    osc_count,
    output logic [COARSE_W-1:0] coarse_code,
    output logic [FINE_W-1:0]   fine_code,
    output logic                coarse_lock,
    output logic                fine_lock,
    output logic                clk_gate_en,
    output logic                cfg_ready
);
    cfg_t                cfg;
    logic                err_neg, err_zero, err_small, coarse_mag_zero;
    logic [COARSE_W-1:0] coarse_delta;
    logic [FINE_W-1:0]   fine_delta;
    logic                tracking, locked;

    fll_cfg_regs #(.BUSY_CYC(BUSY_CYC)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .ready (cfg_ready),
        .cfg   (cfg)
    );

    fll_err_unit #(.CNT_W(CNT_W), .COARSE_SHIFT(COARSE_SHIFT)) u_err (
        .mult            (cfg.mult),
        .count           (osc_count),
        .cstep           (cfg.cstep),
        .fstep           (cfg.fstep),
        .err_neg         (err_neg),
        .err_zero        (err_zero),
        .err_small       (err_small),
        .coarse_mag_zero (coarse_mag_zero),
        .coarse_delta    (coarse_delta),
        .fine_delta      (fine_delta)
    );

    fll_track #(.LOCK_RUN(LOCK_RUN), .REV_LOCK(REV_LOCK)) u_track (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg             (cfg),
        .ref_tick        (ref_tick),
        .err_neg         (err_neg),
        .err_zero        (err_zero),
        .err_small       (err_small),
        .coarse_mag_zero (coarse_mag_zero),
        .coarse_delta    (coarse_delta),
        .fine_delta      (fine_delta),
        .coarse_code     (coarse_code),
        .fine_code       (fine_code),
        .coarse_lock     (coarse_lock),
        .fine_lock       (fine_lock),
        .tracking        (tracking)
    );

    // gate opens when enabled unless waiting for a lock that is not yet there
    always_comb begin
        locked      = cfg.frame ? fine_lock : (coarse_lock & fine_lock);
        clk_gate_en = cfg.enable & ~(tracking & cfg.wait_lock & ~locked);
    end
endmodule

// File: rtl/fll_tuner_chk.sv
// Property checker for fll_tuner, attached by bind below.
module fll_tuner_chk
    import fll_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic                cfg_ready,
    input logic                ref_tick,
    input logic                tracking,
    input logic                frame,
    input logic                wait_lock,
    input logic [COARSE_W-1:0] coarse_code,
    input logic [FINE_W-1:0]   fine_code,
    input logic                coarse_lock,
    input logic                fine_lock,
    input logic                clk_gate_en
);
    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_ready) |=> !cfg_ready ##1 !cfg_ready);

    // R2
    idle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tracking |=> (!coarse_lock && !fine_lock));

    // R3
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && !ref_tick) |=> ($stable(coarse_code) && $stable(fine_code)));

    // R4
    coarse_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && coarse_lock) |=> $stable(coarse_code));

    // R8
    frame_coarse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && frame) |=> $stable(coarse_code));

    // R6
    fine_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fine_lock) |-> $past(ref_tick));

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && wait_lock && !fine_lock) |-> !clk_gate_en);
endmodule

bind fll_tuner fll_tuner_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_ready   (cfg_ready),
    .ref_tick    (ref_tick),
    .tracking    (tracking),
    .frame       (cfg.frame),
    .wait_lock   (cfg.wait_lock),
    .coarse_code (coarse_code),
    .fine_code   (fine_code),
    .coarse_lock (coarse_lock),
    .fine_lock   (fine_lock),
    .clk_gate_en (clk_gate_en)
);

// File: tb/tb_fll_tuner.sv
// Scoreboard bench for fll_tuner: tick tasks queue expected results and a
// monitor compares them one cycle after each reference pulse.
module tb_fll_tuner;
    import fll_pkg::*;

    localparam int EN = 1, CL = 2, WT = 4, FR = 8, NC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        ref_tick = 1'b0;
    logic [15:0] osc_count = '0;
    logic [5:0]  coarse_code;
    logic [9:0]  fine_code;
    logic        coarse_lock, fine_lock, clk_gate_en, cfg_ready;

    int checks = 0;
    int errors = 0;
    bit sb_on  = 1'b1;

    typedef struct {
        int    c;
        int    f;
        int    cl;
        int    fl;
        int    g;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    fll_tuner dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ref_tick(ref_tick), .osc_count(osc_count),
        .coarse_code(coarse_code), .fine_code(fine_code),
        .coarse_lock(coarse_lock), .fine_lock(fine_lock),
        .clk_gate_en(clk_gate_en), .cfg_ready(cfg_ready)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: compare outputs one cycle after each scored pulse
    initial begin
        forever begin
            @(posedge clk);
            if (ref_tick && sb_on) begin : cmp
                exp_t e;
                @(negedge clk);
                if (sbq.size() == 0) begin
                    chk("scoreboard empty", 0, 1);
                end else begin
                    e = sbq.pop_front();
                    chk({e.tag, " coarse"}, int'(coarse_code), e.c);
                    chk({e.tag, " fine"}, int'(fine_code), e.f);
                    chk({e.tag, " coarse_lock"}, int'(coarse_lock), e.cl);
                    chk({e.tag, " fine_lock"}, int'(fine_lock), e.fl);
                    chk({e.tag, " gate"}, int'(clk_gate_en), e.g);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    task automatic wr(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(int cnt);
        @(negedge clk);
        osc_count = 16'(cnt);
        ref_tick  = 1'b1;
        @(negedge clk);
        ref_tick  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic tick(int cnt, int c, int f, int cl, int fl, int g, string tag);
        exp_t e;
        e = '{c, f, cl, fl, g, tag};
        sbq.push_back(e);
        pulse(cnt);
    endtask

    initial begin : main
        int mc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset coarse", int'(coarse_code), 0);
        chk("R2 reset fine", int'(fine_code), 0);
        chk("R2 reset locks", int'({coarse_lock, fine_lock}), 0);
        chk("R7 reset gate", int'(clk_gate_en), 0);
        chk("R1 reset ready", int'(cfg_ready), 1);

        // open loop: calibration drives codes, pulses ignored
        wr(SEL_CAL, (700 << 16) | 33);
        wr(SEL_CTRL, EN | WT);
        chk("R2 open coarse", int'(coarse_code), 33);
        chk("R2 open fine", int'(fine_code), 700);
        chk("R7 open gate", int'(clk_gate_en), 1);
        tick(0, 33, 700, 0, 0, 1, "R2 open pulse ignored");
        tick(5000, 33, 700, 0, 0, 1, "R2 open pulse ignored again");

        // R1 busy window and discarded write
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SEL_CAL; cfg_wdata = (600 << 16) | 40;
        @(negedge clk);
        chk("R1 ready low first", int'(cfg_ready), 0);
        cfg_wdata = (900 << 16) | 50;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R1 ready low second", int'(cfg_ready), 0);
        @(negedge clk);
        chk("R1 ready back", int'(cfg_ready), 1);
        chk("R1 busy write discarded coarse", int'(coarse_code), 40);
        chk("R1 busy write discarded fine", int'(fine_code), 600);

        // closed loop search
        wr(SEL_CTRL, 0);
        wr(SEL_STEP, (50 << 16) | 5);
        wr(SEL_MULT, 1000);
        wr(SEL_CAL, (512 << 16) | 20);
        wr(SEL_CTRL, EN | CL | WT | NC);
        chk("R7 gate shut before lock", int'(clk_gate_en), 0);
        tick(900, 25, 512, 0, 0, 0, "R3 coarse up clamp");
        tick(1100, 20, 512, 0, 0, 0, "R3 coarse down clamp");
        tick(980, 22, 512, 1, 0, 0, "R4 second reversal locks");
        tick(1030, 22, 482, 1, 0, 0, "R5 fine step");
        tick(1080, 22, 432, 1, 0, 0, "R5 fine clamp");
        tick(999, 22, 433, 1, 0, 0, "R6 run one");
        tick(1000, 22, 433, 1, 0, 0, "R6 run two");
        tick(1001, 22, 432, 1, 0, 0, "R6 run three");
        tick(1000, 22, 432, 1, 1, 1, "R6 lock after four R7 gate opens");
        tick(1003, 22, 429, 1, 0, 0, "R6 lock lost R7 gate shuts");
        tick(5000, 22, 379, 1, 0, 0, "R4 coarse frozen");

        // disable clears locks; small error and saturation
        wr(SEL_CTRL, 0);
        chk("R2 disable clears coarse lock", int'(coarse_lock), 0);
        chk("R2 disable reloads coarse", int'(coarse_code), 20);
        wr(SEL_CAL, (512 << 16) | 62);
        wr(SEL_CTRL, EN | CL | NC);
        tick(900, 63, 512, 0, 0, 1, "R3 coarse saturates high");
        tick(900, 63, 512, 0, 0, 1, "R3 coarse held at max");
        tick(995, 63, 512, 1, 0, 1, "R4 zero scaled step locks");

        // settling pause
        wr(SEL_CTRL, 0);
        wr(SEL_CAL, (512 << 16) | 20);
        wr(SEL_CTRL, EN | CL);
        tick(900, 25, 512, 0, 0, 1, "R9 first step");
        tick(900, 25, 512, 0, 0, 1, "R9 pause skips pulse");
        tick(900, 30, 512, 0, 0, 1, "R9 step after pause");

        // frame recovery
        wr(SEL_CTRL, 0);
        wr(SEL_MULT, 48000);
        wr(SEL_CAL, (1000 << 16) | 10);
        wr(SEL_CTRL, EN | FR | WT | NC);
        repeat (20) @(negedge clk);
        chk("R8 no pulses coarse", int'(coarse_code), 10);
        chk("R8 no pulses fine", int'(fine_code), 1000);
        chk("R7 frame gate shut", int'(clk_gate_en), 0);
        tick(47900, 10, 1023, 0, 0, 0, "R5 fine saturates high R8");
        tick(49000, 10, 973, 0, 0, 0, "R8 coarse fixed under large error");
        tick(48000, 10, 973, 0, 0, 0, "R8 run one");
        tick(48001, 10, 972, 0, 0, 0, "R8 run two");
        tick(47999, 10, 973, 0, 0, 0, "R8 run three");
        tick(48000, 10, 973, 0, 1, 1, "R8 fine lock opens R7 gate");

        // convergence against a modelled oscillator, with settling pauses
        wr(SEL_CTRL, 0);
        wr(SEL_MULT, 1000);
        wr(SEL_CAL, (512 << 16) | 20);
        wr(SEL_CTRL, EN | CL | WT);
        sb_on = 1'b0;
        for (int i = 0; i < 300 && !fine_lock; i++) begin
            mc = 600 + 16 * int'(coarse_code) + int'(fine_code) / 8;
            pulse(mc);
        end
        mc = 600 + 16 * int'(coarse_code) + int'(fine_code) / 8;
        chk("R6 model fine lock", int'(fine_lock), 1);
        chk("R4 model coarse lock", int'(coarse_lock), 1);
        // last pulse had error within 1; its one-step correction may add 1
        chk("R6 model residual", int'((mc >= 998) && (mc <= 1002)), 1);
        chk("R7 model gate open", int'(clk_gate_en), 1);

        finish_run();
    end
endmodule